// File: doc/BRIEF.md
# Flag-Based Branch Resolution Unit

This block picks the address of the next instruction for a small 16-bit core. Each cycle the core gives it a snapshot of one instruction: the current instruction pointer, the 8-bit opcode, a flag that says whether the instruction is one word or two, the 16-bit immediate from the second word, one register value, and the zero, lesser and greater condition flags. On the next clock edge the unit registers three results: the resolved next address, a one-cycle redirect pulse that tells the front of the pipeline to flush, and the incremented pointer. The register file stores the incremented pointer when the opcode asks for the next address.

Addresses count 16-bit words. A one-word instruction falls through to the pointer plus one. A two-word instruction falls through to the pointer plus two. The sum wraps modulo 2^ADDR_W. The conditional jumps test flags that a separate compare unit produces. The unit never changes those flags.

Top module: `branch_resolver`

## Requirements
- R1: While rst_n is low, next_ip_o is RESET_IP (default 0), and taken_o, link_o and link_we_o are all 0.
- R2: Any opcode that is not a jump (anything other than 0x18 and 0x21 to 0x27) makes next_ip_o equal ip_i+1 when long_i=0, or ip_i+2 when long_i=1, modulo 2^ADDR_W. The result appears one clock edge after the inputs are sampled.
- R3: Opcode 0x21 sets next_ip_o to imm_i, whatever the flags are.
- R4: Opcode 0x18 sets next_ip_o to rval_i, whatever the flags are.
- R5: Opcode 0x22 jumps to imm_i when flag_z_i=1. Opcode 0x23 jumps to imm_i when flag_z_i=0. Otherwise both fall through as in R2.
- R6: Opcode 0x24 jumps to imm_i when flag_l_i=1. Opcode 0x25 jumps to imm_i when flag_l_i=0. Otherwise both fall through.
- R7: Opcode 0x26 jumps to imm_i when flag_g_i=1. Opcode 0x27 jumps to imm_i when flag_g_i=0. Otherwise both fall through.
- R8: taken_o is 1 in a cycle exactly when next_ip_o differs from that instruction's fall-through address. A jump whose target equals the fall-through address gives taken_o=0.
- R9: link_o always equals the sampled ip_i+1 (modulo 2^ADDR_W). link_we_o is 1 only for opcode 0x19.
- R10: Opcode 0x19 never redirects. It falls through like any other non-jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ip_i | input | ADDR_W | Pointer of the current instruction |
| opcode_i | input | 8 | Opcode of the current instruction |
| long_i | input | 1 | 1 for a two-word instruction |
| imm_i | input | ADDR_W | Immediate jump target from the second word |
| rval_i | input | ADDR_W | Register operand for the indirect jump |
| flag_z_i | input | 1 | Zero flag |
| flag_l_i | input | 1 | Lesser flag |
| flag_g_i | input | 1 | Greater flag |
| next_ip_o | output | ADDR_W | Registered next instruction address |
| taken_o | output | 1 | Registered redirect pulse for flushing |
| link_o | output | ADDR_W | Registered ip_i+1 |
| link_we_o | output | 1 | Registered write strobe for the next-address opcode |

## Verification
The bench builds the unit with ADDR_W=8. With that width, random pointers often land near the top of the address space, so both the +1 and +2 fall-through paths wrap. A random jump target also matches the fall-through address often enough to exercise the case where a jump does not redirect (R8). Directed cases pin each condition opcode against both values of its flag, and they set the unrelated flags to misleading values.

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_IP = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ip_i,
  input  logic [7:0]        opcode_i,
  input  logic              long_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [ADDR_W-1:0] rval_i,
  input  logic              flag_z_i,
  input  logic              flag_l_i,
  input  logic              flag_g_i,
  output logic [ADDR_W-1:0] next_ip_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] link_o,
  output logic              link_we_o
);
  localparam logic [7:0] OP_JMPR = 8'h18;
  localparam logic [7:0] OP_LINK = 8'h19;
  localparam logic [7:0] OP_JMP  = 8'h21;
  localparam logic [7:0] OP_JZ   = 8'h22;
  localparam logic [7:0] OP_JNZ  = 8'h23;
  localparam logic [7:0] OP_JL   = 8'h24;
  localparam logic [7:0] OP_JNL  = 8'h25;
  localparam logic [7:0] OP_JG   = 8'h26;
  localparam logic [7:0] OP_JNG  = 8'h27;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  logic [ADDR_W-1:0] fall, target;
  logic              go;

  assign fall = ip_i + (long_i ? TWO : ONE);

  always_comb begin
    go     = 1'b0;
    target = imm_i;
    unique case (opcode_i)
      OP_JMP:  go = 1'b1;
      OP_JMPR: begin go = 1'b1; target = rval_i; end
      OP_JZ:   go = flag_z_i;
      OP_JNZ:  go = !flag_z_i;
      OP_JL:   go = flag_l_i;
      OP_JNL:  go = !flag_l_i;
      OP_JG:   go = flag_g_i;
      OP_JNG:  go = !flag_g_i;
      default: go = 1'b0;
    endcase
  end

  logic [ADDR_W-1:0] next_d;
  assign next_d = go ? target : fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_ip_o <= RESET_IP;
      taken_o   <= 1'b0;
      link_o    <= '0;
      link_we_o <= 1'b0;
    end else begin
      next_ip_o <= next_d;
      taken_o   <= next_d != fall;
      link_o    <= ip_i + ONE;
      link_we_o <= opcode_i == OP_LINK;
    end
  end

  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!taken_o && !link_we_o));

  assert_fallthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
    live && !taken_o |-> next_ip_o == $past(ip_i) + ($past(long_i) ? TWO : ONE));

  assert_jmp_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(opcode_i) == OP_JMP |-> next_ip_o == $past(imm_i));

  assert_jmpr_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(opcode_i) == OP_JMPR |-> next_ip_o == $past(rval_i));

  assert_zero_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
    live && (($past(opcode_i) == OP_JZ && $past(flag_z_i)) ||
             ($past(opcode_i) == OP_JNZ && !$past(flag_z_i)))
    |-> next_ip_o == $past(imm_i));

  assert_taken_diff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    live && taken_o |-> next_ip_o != $past(ip_i) + ($past(long_i) ? TWO : ONE));

  assert_link_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> link_o == $past(ip_i) + ONE);

  assert_link_no_redirect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> !taken_o);
endmodule

// File: tb/tb_branch_resolver.sv
module tb_branch_resolver;
  localparam int AW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] ip, imm, rval;
  logic [7:0] op;
  logic lng, fz, fl, fg;
  logic [AW-1:0] next_ip, link;
  logic taken, link_we;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  branch_resolver #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ip_i(ip), .opcode_i(op), .long_i(lng),
    .imm_i(imm), .rval_i(rval), .flag_z_i(fz), .flag_l_i(fl), .flag_g_i(fg),
    .next_ip_o(next_ip), .taken_o(taken), .link_o(link), .link_we_o(link_we));

  function automatic logic [AW-1:0] fall_of(logic [AW-1:0] p, logic l);
    return p + (l ? AW'(2) : AW'(1));
  endfunction

  function automatic logic [AW-1:0] exp_next(logic [7:0] o, logic [AW-1:0] p, logic l,
      logic [AW-1:0] im, logic [AW-1:0] rv, logic z, logic ls, logic g);
    case (o)
      8'h21: return im;
      8'h18: return rv;
      8'h22: return z ? im : fall_of(p, l);
      8'h23: return !z ? im : fall_of(p, l);
      8'h24: return ls ? im : fall_of(p, l);
      8'h25: return !ls ? im : fall_of(p, l);
      8'h26: return g ? im : fall_of(p, l);
      8'h27: return !g ? im : fall_of(p, l);
      default: return fall_of(p, l);
    endcase
  endfunction

  function automatic string req_of(logic [7:0] o);
    case (o)
      8'h21: return "R3";
      8'h18: return "R4";
      8'h22, 8'h23: return "R5";
      8'h24, 8'h25: return "R6";
      8'h26, 8'h27: return "R7";
      8'h19: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic apply(logic [7:0] o, logic [AW-1:0] p, logic l, logic [AW-1:0] im,
                       logic [AW-1:0] rv, logic z, logic ls, logic g);
    logic [AW-1:0] en, ef;
    op = o; ip = p; lng = l; imm = im; rval = rv; fz = z; fl = ls; fg = g;
    en = exp_next(o, p, l, im, rv, z, ls, g);
    ef = fall_of(p, l);
    @(posedge clk); #1;
    check(req_of(o), "next_ip", 32'(next_ip), 32'(en));
    check("R8", "taken", 32'(taken), 32'(en != ef));
    check("R9", "link", 32'(link), 32'(AW'(p + AW'(1))));
    check("R9", "link_we", 32'(link_we), 32'(o == 8'h19));
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20061);
    op = 8'h21; ip = 8'h55; lng = 1'b1; imm = 8'hAA; rval = 8'h33;
    fz = 1'b1; fl = 1'b1; fg = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "next_ip", 32'(next_ip), 32'h0);
    check("R1", "taken", 32'(taken), 32'h0);
    check("R1", "link", 32'(link), 32'h0);
    check("R1", "link_we", 32'(link_we), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 wrap for both lengths
    apply(8'h06, 8'hFF, 1'b0, 8'h10, 8'h20, 1, 1, 1);
    apply(8'h20, 8'hFF, 1'b1, 8'h10, 8'h20, 0, 0, 0);
    apply(8'h02, 8'hFE, 1'b1, 8'h10, 8'h20, 1, 0, 1);
    // R3 / R4 regardless of flags
    apply(8'h21, 8'h40, 1'b1, 8'h90, 8'h20, 0, 0, 0);
    apply(8'h18, 8'h40, 1'b0, 8'h90, 8'hC3, 1, 1, 1);
    // R5-R7 each polarity with misleading other flags
    apply(8'h22, 8'h10, 1'b1, 8'h80, 8'h00, 1, 0, 0);
    apply(8'h22, 8'h10, 1'b1, 8'h80, 8'h00, 0, 1, 1);
    apply(8'h23, 8'h10, 1'b1, 8'h80, 8'h00, 0, 1, 1);
    apply(8'h23, 8'h10, 1'b1, 8'h80, 8'h00, 1, 0, 0);
    apply(8'h24, 8'h10, 1'b1, 8'h80, 8'h00, 0, 1, 0);
    apply(8'h24, 8'h10, 1'b1, 8'h80, 8'h00, 1, 0, 1);
    apply(8'h25, 8'h10, 1'b1, 8'h80, 8'h00, 1, 0, 1);
    apply(8'h25, 8'h10, 1'b1, 8'h80, 8'h00, 0, 1, 0);
    apply(8'h26, 8'h10, 1'b1, 8'h80, 8'h00, 0, 0, 1);
    apply(8'h26, 8'h10, 1'b1, 8'h80, 8'h00, 1, 1, 0);
    apply(8'h27, 8'h10, 1'b1, 8'h80, 8'h00, 1, 1, 0);
    apply(8'h27, 8'h10, 1'b1, 8'h80, 8'h00, 0, 0, 1);
    // R8 target equal to fall-through
    apply(8'h21, 8'h30, 1'b1, 8'h32, 8'h00, 0, 0, 0);
    apply(8'h18, 8'h30, 1'b0, 8'h00, 8'h31, 0, 0, 0);
    apply(8'h21, 8'hFF, 1'b1, 8'h01, 8'h00, 0, 0, 0);
    // R9 / R10 link opcode, including wrap
    apply(8'h19, 8'h7E, 1'b0, 8'h05, 8'h06, 1, 1, 1);
    apply(8'h19, 8'hFF, 1'b0, 8'h05, 8'h06, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [7:0] o;
      r = int'($urandom % 12);
      if (r < 8) o = 8'h21 + 8'(r);
      else if (r == 8) o = 8'h18;
      else if (r == 9) o = 8'h19;
      else o = 8'($urandom);
      if (o == 8'h20 && r != 11) o = 8'h18;
      apply(o, AW'($urandom), 1'($urandom), AW'($urandom), AW'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule